// File: doc/BRIEF.md
# PLL Configuration Word Calculator

This block turns a reference clock frequency in kHz and a wanted PLL output rate in kbps into a 16-bit PLL setup word for a display bridge. The word carries a reference pre-divider, a feedback multiplier and a two-bit rate band code. Alongside the word the block reports the rate the PLL will actually reach and a 6-bit low-power clock divider field. The wanted rate is normally formed upstream as the pixel clock in kHz times (bits per pixel / lane count + 1).

A one-cycle `start` strobe captures both operands. A controller with named states then runs four divisions in a fixed order through one shared restoring divider that makes one quotient bit per cycle. The order is pre-divider, multiplier, achieved rate, low-power divider. After the four divisions it packs the results and raises `done` for one cycle. The states are IDLE, PRE_GO, PRE_WAIT, MUL_GO, MUL_WAIT, ACH_GO, ACH_WAIT, LP_GO, LP_WAIT and PACK:
- IDLE moves to PRE_GO on `start` with a non-zero reference. With a zero reference it stays in IDLE and reports an error at once.
- Each *_GO state launches the divider and moves on to its *_WAIT state.
- Each *_WAIT state moves to the next *_GO state, or from LP_WAIT to PACK, when the divider's done pulse arrives.
- PACK writes the outputs and returns to IDLE.

Top module: `pllcfg_calc`

## Requirements
- R1: After reset, `done`, `busy`, `mul_ovf` and `ref_err` are 0 and `cfg_word`, `ach_kbps` and `lp_div` are all zero.
- R2: `busy` is high from the cycle after an accepted `start` until the result is written. `done` is never high together with `busy` and lasts one cycle per result. Outputs change only in a `done` cycle and hold otherwise. A `start` seen while `busy` is high is ignored.
- R3: The pre-divider D is the largest value in 1..31 with reference ≥ 2000·D. It is 1 when the reference is below 4000 kHz and 31 whenever the reference is 62000 kHz or more.
- R4: The multiplier M is the ceiling of rate·D / reference.
- R5: When M exceeds 255, `mul_ovf` is 1 and the multiplier field holds 255. That saturated value is then used for every later step. Otherwise `mul_ovf` is 0.
- R6: `ach_kbps` equals floor(reference·M / D), using the saturated M.
- R7: The band code is 3 when the achieved rate is ≥ 501000, 2 when it is ≥ 251000, 1 when it is ≥ 126000, and 0 below that.
- R8: `cfg_word` holds the band in bits 15:14, a 0 in bit 13, D in bits 12:8 and M in bits 7:0.
- R9: `lp_div` equals (floor(achieved / 40000) − 1) modulo 64, so an achieved rate below 40000 gives 63.
- R10: A `start` with a zero reference sets `ref_err`. It raises `done` in the cycle after the sampling edge with the word, achieved rate, divider field and `mul_ovf` all zero. A valid result clears `ref_err`.
- R11: For a non-zero reference, `done` rises after exactly 4·(DIV_W+2)+1 clock edges, counted from the edge that samples `start`. With the default DIV_W of 40 that is 169 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; operands are sampled with it |
| ref_khz | input | 32 | Reference clock frequency in kHz |
| rate_kbps | input | 32 | Wanted PLL rate in kbps |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse; results valid from this cycle on |
| cfg_word | output | 16 | Packed band, pre-divider and multiplier |
| ach_kbps | output | 40 | Achieved PLL rate in kbps |
| lp_div | output | 6 | Encoded low-power clock divider |
| mul_ovf | output | 1 | Multiplier saturated at 255 |
| ref_err | output | 1 | Last request had a zero reference |

## Verification
The assertions rely on three properties of the inputs. `start` is only meaningful while `busy` is low. The product of the wanted rate and 31 fits in the divider width. The divider never sees a zero denominator, because the controller filters a zero reference before any division starts. The stimulus respects the first two by construction: its wanted rates stay within 32 bits and it sends no request whose result it does not wait for. It issues one deliberate `start` during a busy window to confirm that request is dropped. The operands are chosen to land exactly on each pre-divider step and at the 31 cap. They also sit on both sides of the 501000 band edge, saturate the multiplier, and give an achieved rate below 40000 so the divider field wraps.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int unsigned MIN_REF_KHZ = 2000;
    localparam int unsigned LP_STEP     = 40000;
    localparam int unsigned BAND3_MIN   = 501000;
    localparam int unsigned BAND2_MIN   = 251000;
    localparam int unsigned BAND1_MIN   = 126000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_GO,
        ST_PRE_WAIT,
        ST_MUL_GO,
        ST_MUL_WAIT,
        ST_ACH_GO,
        ST_ACH_WAIT,
        ST_LP_GO,
        ST_LP_WAIT,
        ST_PACK
    } calc_state_t;
endpackage

// File: rtl/pllcfg_restoring_div.sv
module pllcfg_restoring_div #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]   rem_q, quo_q, den_q, num_q;
    logic [CNT_W-1:0] cnt_q;
    logic           busy_q, done_q;
    logic [W:0]     shifted, trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= num;
                num_q  <= num;
                den_q  <= den;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quo  = quo_q;
    assign rem  = rem_q;

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rem_q < den_q)); // R6
    AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (({{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q}) + {{W{1'b0}}, rem_q}
                    == {{W{1'b0}}, num_q})); // R6
endmodule

// File: rtl/pllcfg_band.sv
module pllcfg_band #(
    parameter int W = 40
) (
    input  logic [W-1:0] rate,
    output logic [1:0]   band
);
    import pllcfg_pkg::*;

    always_comb begin
        if (rate >= W'(BAND3_MIN))      band = 2'd3;
        else if (rate >= W'(BAND2_MIN)) band = 2'd2;
        else if (rate >= W'(BAND1_MIN)) band = 2'd1;
        else                            band = 2'd0;
    end
endmodule

// File: rtl/pllcfg_calc.sv
module pllcfg_calc #(
    parameter int REF_W  = 32,
    parameter int RATE_W = 32,
    parameter int PDIV_W = 5,
    parameter int MUL_W  = 8,
    parameter int LP_W   = 6,
    parameter int DIV_W  = REF_W + MUL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REF_W-1:0]  ref_khz,
    input  logic [RATE_W-1:0] rate_kbps,
    output logic              busy,
    output logic              done,
    output logic [15:0]       cfg_word,
    output logic [DIV_W-1:0]  ach_kbps,
    output logic [LP_W-1:0]   lp_div,
    output logic              mul_ovf,
    output logic              ref_err
);
    import pllcfg_pkg::*;

    localparam logic [PDIV_W-1:0] PDIV_MAX = '1;
    localparam logic [MUL_W-1:0]  MUL_MAX  = '1;

    calc_state_t state_q, state_d;

    logic [REF_W-1:0]  ref_q;
    logic [RATE_W-1:0] rate_q;
    logic [PDIV_W-1:0] pre_q;
    logic [MUL_W-1:0]  mul_q;
    logic              ovf_q;
    logic [DIV_W-1:0]  ach_q;
    logic [LP_W-1:0]   lp_q;

    logic              div_go, div_busy, div_done;
    logic [DIV_W-1:0]  div_num, div_den, div_quo, div_rem;
    logic [1:0]        band;

    logic [PDIV_W-1:0] pre_sel;
    logic [DIV_W-1:0]  mul_ceil;
    logic              mul_big;
    logic [LP_W-1:0]   lp_sel;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start && (ref_khz != '0)) state_d = ST_PRE_GO;
            ST_PRE_GO:   state_d = ST_PRE_WAIT;
            ST_PRE_WAIT: if (div_done) state_d = ST_MUL_GO;
            ST_MUL_GO:   state_d = ST_MUL_WAIT;
            ST_MUL_WAIT: if (div_done) state_d = ST_ACH_GO;
            ST_ACH_GO:   state_d = ST_ACH_WAIT;
            ST_ACH_WAIT: if (div_done) state_d = ST_LP_GO;
            ST_LP_GO:    state_d = ST_LP_WAIT;
            ST_LP_WAIT:  if (div_done) state_d = ST_PACK;
            ST_PACK:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // ---------------- divider operand select ----------------
    always_comb begin
        div_go  = 1'b0;
        div_num = '0;
        div_den = DIV_W'(1);
        unique case (state_q)
            ST_PRE_GO: begin
                div_go  = 1'b1;
                div_num = DIV_W'(ref_q);
                div_den = DIV_W'(MIN_REF_KHZ);
            end
            ST_MUL_GO: begin
                div_go  = 1'b1;
                div_num = DIV_W'(rate_q) * DIV_W'(pre_q);
                div_den = DIV_W'(ref_q);
            end
            ST_ACH_GO: begin
                div_go  = 1'b1;
                div_num = DIV_W'(ref_q) * DIV_W'(mul_q);
                div_den = DIV_W'(pre_q);
            end
            ST_LP_GO: begin
                div_go  = 1'b1;
                div_num = ach_q;
                div_den = DIV_W'(LP_STEP);
            end
            default: begin
                div_go  = 1'b0;
            end
        endcase
    end

    pllcfg_restoring_div #(.W(DIV_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    pllcfg_band #(.W(DIV_W)) band_i (
        .rate (ach_q),
        .band (band)
    );

    // ---------------- quotient post-processing ----------------
    always_comb begin
        if (div_quo == '0)                     pre_sel = PDIV_W'(1);
        else if (div_quo > DIV_W'(PDIV_MAX))   pre_sel = PDIV_MAX;
        else                                   pre_sel = div_quo[PDIV_W-1:0];
        mul_ceil = div_quo + DIV_W'(div_rem != '0);
        mul_big  = mul_ceil > DIV_W'(MUL_MAX);
        lp_sel   = div_quo[LP_W-1:0] - 1'b1;
    end

    // ---------------- working registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            rate_q <= '0;
            pre_q  <= '0;
            mul_q  <= '0;
            ovf_q  <= 1'b0;
            ach_q  <= '0;
            lp_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ref_q  <= ref_khz;
                    rate_q <= rate_kbps;
                end
                ST_PRE_WAIT: if (div_done) pre_q <= pre_sel;
                ST_MUL_WAIT: if (div_done) begin
                    mul_q <= mul_big ? MUL_MAX : mul_ceil[MUL_W-1:0];
                    ovf_q <= mul_big;
                end
                ST_ACH_WAIT: if (div_done) ach_q <= div_quo;
                ST_LP_WAIT:  if (div_done) lp_q <= lp_sel;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            cfg_word <= '0;
            ach_kbps <= '0;
            lp_div   <= '0;
            mul_ovf  <= 1'b0;
            ref_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE && start && ref_khz == '0) begin
                done     <= 1'b1;
                cfg_word <= '0;
                ach_kbps <= '0;
                lp_div   <= '0;
                mul_ovf  <= 1'b0;
                ref_err  <= 1'b1;
            end else if (state_q == ST_PACK) begin
                done     <= 1'b1;
                cfg_word <= {band, 1'b0, pre_q, mul_q};
                ach_kbps <= ach_q;
                lp_div   <= lp_q;
                mul_ovf  <= ovf_q;
                ref_err  <= 1'b0;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

    // ---------------- assertions ----------------
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R2
    AST_HOLD_BETWEEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cfg_word) && $stable(ach_kbps) && $stable(lp_div))); // R2
    AST_DIV_IDLE_AT_GO: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy); // R11
    AST_MUL_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mul_ovf) |-> (cfg_word[7:0] == 8'hFF)); // R5
    AST_ERR_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ref_err) |-> (cfg_word == '0 && ach_kbps == '0 && lp_div == '0 && !mul_ovf)); // R10
    AST_PREDIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ref_err) |-> (cfg_word[12:8] != '0 && !cfg_word[13])); // R8
    AST_TOP_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ach_kbps >= DIV_W'(BAND3_MIN)) |-> (cfg_word[15:14] == 2'd3)); // R7
endmodule

// File: tb/pllcfg_calc_tb_top.sv
module pllcfg_calc_tb_top;
    localparam int DIV_W = 40;
    localparam int LAT   = 4 * (DIV_W + 2) + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_khz = '0;
    logic [31:0] rate_kbps = '0;
    logic        busy, done, mul_ovf, ref_err;
    logic [15:0] cfg_word;
    logic [DIV_W-1:0] ach_kbps;
    logic [5:0]  lp_div;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // model state
    int          m_cnt = -1;
    longint unsigned p_word, p_ach, p_lp, p_ovf, p_err;
    longint unsigned s_word = 0, s_ach = 0, s_lp = 0, s_ovf = 0, s_err = 0;

    always #5 clk = ~clk;

    pllcfg_calc dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz),
        .rate_kbps(rate_kbps), .busy(busy), .done(done), .cfg_word(cfg_word),
        .ach_kbps(ach_kbps), .lp_div(lp_div), .mul_ovf(mul_ovf), .ref_err(ref_err)
    );

    task automatic expect_of(input longint unsigned r, input longint unsigned w);
        longint unsigned d, m, a, band;
        if (r == 0) begin
            p_word = 0; p_ach = 0; p_lp = 0; p_ovf = 0; p_err = 1;
            return;
        end
        d = 1;
        while (d < 31 && (r / (d + 1)) >= 2000) d++;          // R3
        m = (w * d + r - 1) / r;                              // R4
        p_ovf = (m > 255) ? 1 : 0;                            // R5
        if (m > 255) m = 255;
        a = (r * m) / d;                                      // R6
        if (a >= 501000) band = 3;                            // R7
        else if (a >= 251000) band = 2;
        else if (a >= 126000) band = 1;
        else band = 0;
        p_word = (band << 14) | (d << 8) | m;                 // R8
        p_ach  = a;
        p_lp   = ((a / 40000) - 1) & 63;                      // R9
        p_err  = 0;
    endtask

    // behavioural reference: request tracking per clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = -1;
        end else if (m_cnt <= 0 && start) begin
            expect_of(ref_khz, rate_kbps);
            if (p_err != 0) begin
                m_cnt = 0;
                s_word = p_word; s_ach = p_ach; s_lp = p_lp; s_ovf = p_ovf; s_err = p_err;
            end else begin
                m_cnt = LAT;
            end
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                s_word = p_word; s_ach = p_ach; s_lp = p_lp; s_ovf = p_ovf; s_err = p_err;
            end
        end else begin
            m_cnt = -1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=0x%0h expected=0x%0h", tag, cyc, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(done == (m_cnt == 0), "R11 done timing", done, m_cnt == 0);
            chk(busy == (m_cnt > 0), "R2 busy", busy, m_cnt > 0);
            chk(cfg_word[15:14] == s_word[15:14], "R7 band", cfg_word[15:14], s_word[15:14]);
            chk(cfg_word[13:8] == s_word[13:8], "R3 pre-divider", cfg_word[13:8], s_word[13:8]);
            chk(cfg_word[7:0] == s_word[7:0], "R4 multiplier", cfg_word[7:0], s_word[7:0]);
            chk(ach_kbps == s_ach, "R6 achieved", ach_kbps, s_ach);
            chk(lp_div == s_lp, "R9 lp divider", lp_div, s_lp);
            chk(mul_ovf == s_ovf, "R5 overflow", mul_ovf, s_ovf);
            chk(ref_err == s_err, "R10 ref error", ref_err, s_err);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(input logic [31:0] r, input logic [31:0] w);
        @(negedge clk);
        ref_khz = r; rate_kbps = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 0 && busy == 0 && cfg_word == 0 && ach_kbps == 0 && lp_div == 0
            && mul_ovf == 0 && ref_err == 0, "R1 reset", {done, busy, mul_ovf, ref_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(32'd24000, 32'd500000);      // R7 just below band 3
        issue(32'd24000, 32'd501000);      // R7 at/above band 3
        issue(32'd0, 32'd400000);          // R10 zero reference
        issue(32'd1000, 32'd100000);       // R3 small reference, D=1
        issue(32'd3999, 32'd200000);       // R3 D=1 edge
        issue(32'd4000, 32'd200000);       // R3 D=2 edge
        issue(32'd62000, 32'd300000);      // R3 exactly 31
        issue(32'd100000, 32'd700000);     // R3 cap
        issue(32'd2000, 32'd1000000);      // R5 saturation
        issue(32'd19200, 32'd30000);       // R9 wrap below 40000
        issue(32'd12000, 32'd0);           // R4 zero rate
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF); // R6 wide operands
        issue(32'd0, 32'd0);               // R10 again, then valid clears it
        issue(32'd26000, 32'd130000);      // R7 band 1

        // R2: a start while busy is dropped
        @(negedge clk);
        ref_khz = 32'd27000; rate_kbps = 32'd260000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        ref_khz = 32'd5000; rate_kbps = 32'd999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt > 0) @(negedge clk);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule